// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block picks the way of a set-associative cache (one to four ways) that a line fill should overwrite. The replacement policy is fixed at build time by a parameter. Three policies are available. In the random policy a small free-running counter points at the candidate. In the least-recently-replaced policy, which is for two ways only, one bit per line records the way filled last. In the least-recently-used policy, each line keeps a compact code for the full recency order of its ways.

The cache controller drives the line index of the current lookup and the lock bits read for that line. It receives the victim way in the same cycle. When it reports a hit (access valid plus hit way) or a fill, the history of the indexed line is updated on the next clock edge. A fill always writes the way currently shown on the victim output. A way whose lock bit is set is never offered as victim, unless every way of the line is locked. In that case a flag output is raised and the highest-numbered way is returned.

Top module: `way_victim_sel`

## Requirements
- R1: When WAYS is 1, the victim is always way 0. The fallback flag then simply follows the lock bit of way 0 whenever locking is enabled.
- R2: Random policy. A counter is cleared by reset and advances by one on every clock edge. It is 1 bit wide for 2 ways and 2 bits wide for 3 or 4 ways. With no locks, the victim equals the counter value, except that for 3 ways a counter value of 3 selects way 0.
- R3: Random policy. If the counter's candidate way is locked, the victim is the next unlocked way found by searching upward from the candidate and wrapping past the top way to way 0.
- R4: Least-recently-replaced policy (2 ways). Each line holds one bit naming the way filled last; reset sets it to way 0. The victim is the other way. If that way is locked and the last-filled way is not, the last-filled way is returned instead.
- R5: Least-recently-used policy. The victim is the unlocked way of the indexed line that was used longest ago. A hit uses the hit way, and a fill uses the victim way.
- R6: After reset, every line under the least-recently-used policy ranks way 0 as oldest and way WAYS-1 as newest.
- R7: If a fill and a hit arrive in the same cycle, only the fill updates the history. A hit whose way number is WAYS or above has no effect.
- R8: An update changes only the history of the line on the index input. All other lines keep their state.
- R9: When every way of the indexed line is locked, the victim is way WAYS-1 and the all-locked flag is 1. Otherwise the flag is 0.
- R10: With LOCK_EN set to 0, the lock inputs are ignored: the victim is unaffected by them and the flag stays 0.
- R11: The victim and the flag follow the index and lock inputs within the same cycle. A history update becomes visible from the cycle after the edge that performs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_i | input | IDXW = log2(LINES) | Line index of the current lookup |
| acc_valid_i | input | 1 | A hit occurred on the indexed line |
| hit_way_i | input | WW = max(1, log2(WAYS)) | Way that hit |
| fill_i | input | 1 | The indexed line is being filled into the victim way |
| lock_i | input | WAYS | Lock bits of the indexed line, one per way |
| victim_o | output | WW | Way to evict |
| all_locked_o | output | 1 | Every way of the indexed line is locked |

## Verification
The bench builds six copies of the block side by side on 16 lines, all driven by the same stimulus. The configurations are: four-way least-recently-used with locking; three-way least-recently-used without locking; two-way least-recently-replaced with locking; four-way and three-way random, with and without locking; and a single-way build. The four-way recency build covers the full 24-order code, lock skipping and the all-locked fallback. The three-way builds add the non-power-of-two counter wrap, the out-of-range hit way and the ignored lock inputs. The two-way and single-way builds cover the alternating fill pattern and the degenerate case.

// File: rtl/wvs_pkg.sv
`timescale 1ns/1ps
package wvs_pkg;

   typedef enum logic [1:0] {
      POL_RANDOM = 2'd0,
      POL_LRR    = 2'd1,
      POL_LRU    = 2'd2
   } policy_e;

   localparam int MAX_WAYS   = 4;
   localparam int RANK_MAX_W = 5;

   typedef logic [1:0] way_t;
   // position 0 holds the oldest way, position n-1 the newest
   typedef way_t [MAX_WAYS-1:0] order_t;

   function automatic int fact(input int n);
      int f;
      f = 1;
      for (int i = 2; i <= n; i++) f = f * i;
      return f;
   endfunction

   function automatic int rank_width(input int n);
      return (n <= 2) ? 1 : $clog2(fact(n));
   endfunction

   // factorial-base rank -> recency order; rank 0 is way 0 oldest upward
   function automatic order_t rank_to_order(input logic [RANK_MAX_W-1:0] rank, input int n);
      order_t               ord;
      logic [MAX_WAYS-1:0]  used;
      int                   rem;
      int                   base;
      int                   digit;
      int                   seen;
      ord  = '0;
      used = '0;
      rem  = int'(rank);
      for (int p = 0; p < MAX_WAYS; p++) begin
         if (p < n) begin
            base  = fact(n - 1 - p);
            digit = rem / base;
            rem   = rem % base;
            seen  = 0;
            for (int w = 0; w < MAX_WAYS; w++) begin
               if (w < n && !used[w]) begin
                  if (seen == digit) begin
                     ord[p]  = way_t'(w);
                     used[w] = 1'b1;
                  end
                  seen++;
               end
            end
         end
      end
      return ord;
   endfunction

   function automatic logic [RANK_MAX_W-1:0] order_to_rank(input order_t ord, input int n);
      logic [MAX_WAYS-1:0] used;
      int                  total;
      int                  smaller;
      used  = '0;
      total = 0;
      for (int p = 0; p < MAX_WAYS; p++) begin
         if (p < n) begin
            smaller = 0;
            for (int w = 0; w < MAX_WAYS; w++) begin
               if (w < int'(ord[p]) && !used[w]) smaller++;
            end
            total = total + smaller * fact(n - 1 - p);
            used[ord[p]] = 1'b1;
         end
      end
      return RANK_MAX_W'(total);
   endfunction

   // move one way to the newest slot, keeping the others in order
   function automatic order_t make_newest(input order_t ord, input way_t way, input int n);
      order_t nxt;
      int     q;
      nxt = '0;
      q   = 0;
      for (int p = 0; p < MAX_WAYS; p++) begin
         if (p < n && ord[p] != way) begin
            nxt[q] = ord[p];
            q++;
         end
      end
      nxt[n-1] = way;
      return nxt;
   endfunction

endpackage

// File: rtl/wvs_rand_pick.sv
`timescale 1ns/1ps
module wvs_rand_pick
   import wvs_pkg::*;
#(
   parameter  int WAYS = 4,
   localparam int WW   = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int CW   = (WAYS <= 2) ? 1 : 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [WAYS-1:0] lock_i,
   output logic [WW-1:0]   victim_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      int   start;
      int   w;
      logic found;
      start = int'(cnt_q);
      if (start >= WAYS) start = start - WAYS;
      found    = 1'b0;
      w        = 0;
      victim_o = WW'(WAYS - 1);
      for (int k = 0; k < WAYS; k++) begin
         w = (start + k) % WAYS;
         if (!found && !lock_i[w]) begin
            victim_o = WW'(w);
            found    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/wvs_lrr.sv
`timescale 1ns/1ps
module wvs_lrr #(
   parameter  int LINES = 64,
   localparam int IDXW  = $clog2(LINES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] idx_i,
   input  logic            fill_i,
   input  logic [1:0]      lock_i,
   output logic [0:0]      victim_o
);

   logic [LINES-1:0] last_q;
   logic             pref;

   always_comb begin
      pref = ~last_q[idx_i];
      if (!lock_i[pref])       victim_o = pref;
      else if (!lock_i[~pref]) victim_o = ~pref;
      else                     victim_o = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      last_q         <= '0;
      else if (fill_i) last_q[idx_i]  <= victim_o[0];
   end

endmodule

// File: rtl/wvs_lru.sv
`timescale 1ns/1ps
module wvs_lru
   import wvs_pkg::*;
#(
   parameter  int WAYS  = 4,
   parameter  int LINES = 64,
   localparam int IDXW  = $clog2(LINES),
   localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int RW    = rank_width(WAYS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] idx_i,
   input  logic            acc_valid_i,
   input  logic [WW-1:0]   hit_way_i,
   input  logic            fill_i,
   input  logic [WAYS-1:0] lock_i,
   output logic [WW-1:0]   victim_o
);

   logic [RW-1:0]       hist_q [LINES];
   order_t              cur_ord;
   logic [MAX_WAYS-1:0] lock_x;
   logic                upd_en;
   way_t                upd_way;
   logic [RW-1:0]       new_rank;

   assign lock_x = MAX_WAYS'(lock_i);

   always_comb cur_ord = rank_to_order(RANK_MAX_W'(hist_q[idx_i]), WAYS);

   // oldest unlocked way wins
   always_comb begin
      logic found;
      found    = 1'b0;
      victim_o = WW'(WAYS - 1);
      for (int p = 0; p < WAYS; p++) begin
         if (!found && !lock_x[cur_ord[p]]) begin
            victim_o = WW'(cur_ord[p]);
            found    = 1'b1;
         end
      end
   end

   always_comb begin
      upd_en  = 1'b0;
      upd_way = '0;
      if (fill_i) begin
         upd_en  = 1'b1;
         upd_way = way_t'(victim_o);
      end else if (acc_valid_i && int'(hit_way_i) < WAYS) begin
         upd_en  = 1'b1;
         upd_way = way_t'(hit_way_i);
      end
   end

   assign new_rank = RW'(order_to_rank(make_newest(cur_ord, upd_way, WAYS), WAYS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) hist_q[i] <= '0;
      end else if (upd_en) begin
         hist_q[idx_i] <= new_rank;
      end
   end

endmodule

// File: rtl/way_victim_sel.sv
`timescale 1ns/1ps
module way_victim_sel
   import wvs_pkg::*;
#(
   parameter  int      WAYS    = 4,
   parameter  int      LINES   = 64,
   parameter  policy_e POLICY  = POL_LRU,
   parameter  bit      LOCK_EN = 1'b1,
   localparam int      IDXW    = $clog2(LINES),
   localparam int      WW      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [IDXW-1:0] idx_i,
   input  logic            acc_valid_i,
   input  logic [WW-1:0]   hit_way_i,
   input  logic            fill_i,
   input  logic [WAYS-1:0] lock_i,
   output logic [WW-1:0]   victim_o,
   output logic            all_locked_o
);

   // elaboration-time parameter checks
   if (WAYS < 1 || WAYS > MAX_WAYS) begin : g_bad_ways
      $error("way_victim_sel: WAYS must be 1..4");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("way_victim_sel: LINES must be a power of two >= 2");
   end
   if (POLICY == POL_LRR && WAYS > 2) begin : g_bad_lrr
      $error("way_victim_sel: replaced-order policy needs at most 2 ways");
   end

   logic [WAYS-1:0] lock_eff;

   if (LOCK_EN) begin : g_lock
      assign lock_eff = lock_i;
   end else begin : g_nolock
      logic unused_lock;
      assign lock_eff    = '0;
      assign unused_lock = ^lock_i;
   end

   assign all_locked_o = &lock_eff;

   if (WAYS == 1) begin : g_single
      logic unused_single;
      assign victim_o      = '0;
      assign unused_single = ^{clk, rst_n, idx_i, acc_valid_i, hit_way_i, fill_i};
   end else if (POLICY == POL_RANDOM) begin : g_rand
      logic unused_rand;
      assign unused_rand = ^{idx_i, acc_valid_i, hit_way_i, fill_i};
      wvs_rand_pick #(.WAYS(WAYS)) u_pick (
         .clk      (clk),
         .rst_n    (rst_n),
         .lock_i   (lock_eff),
         .victim_o (victim_o)
      );
   end else if (POLICY == POL_LRR) begin : g_lrr
      logic unused_lrr;
      assign unused_lrr = ^{acc_valid_i, hit_way_i};
      wvs_lrr #(.LINES(LINES)) u_lrr (
         .clk      (clk),
         .rst_n    (rst_n),
         .idx_i    (idx_i),
         .fill_i   (fill_i),
         .lock_i   (2'(lock_eff)),
         .victim_o (victim_o)
      );
   end else begin : g_lru
      wvs_lru #(.WAYS(WAYS), .LINES(LINES)) u_lru (
         .clk         (clk),
         .rst_n       (rst_n),
         .idx_i       (idx_i),
         .acc_valid_i (acc_valid_i),
         .hit_way_i   (hit_way_i),
         .fill_i      (fill_i),
         .lock_i      (lock_eff),
         .victim_o    (victim_o)
      );
   end

endmodule

// File: rtl/wvs_check.sv
`timescale 1ns/1ps
module wvs_check
   import wvs_pkg::*;
#(
   parameter  int      WAYS    = 4,
   parameter  int      LINES   = 64,
   parameter  policy_e POLICY  = POL_LRU,
   parameter  bit      LOCK_EN = 1'b1,
   localparam int      IDXW    = $clog2(LINES),
   localparam int      WW      = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input logic            clk,
   input logic            rst_n,
   input logic [IDXW-1:0] idx_i,
   input logic            acc_valid_i,
   input logic [WW-1:0]   hit_way_i,
   input logic            fill_i,
   input logic [WAYS-1:0] lock_i,
   input logic [WW-1:0]   victim_o,
   input logic            all_locked_o
);

   logic            lock_clear;
   logic [WAYS-1:0] lock_seen;

   assign lock_seen  = LOCK_EN ? lock_i : '0;
   assign lock_clear = (lock_seen == '0);

   assert_fallback_R9: assert property (@(posedge clk) disable iff (!rst_n)
      all_locked_o |-> (int'(victim_o) == WAYS - 1));

   // also covers R4 and R5: a locked way is never offered while another is free
   assert_skip_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !all_locked_o |-> !lock_seen[victim_o]);

   if (!LOCK_EN) begin : g_chk_nolock
      assert_lock_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !all_locked_o);
   end

   if (WAYS == 1) begin : g_chk_single
      assert_single_way_R1: assert property (@(posedge clk) disable iff (!rst_n)
         victim_o == '0);
   end

   if (WAYS > 1 && POLICY == POL_RANDOM && (WAYS == 2 || WAYS == 4)) begin : g_chk_rand
      assert_rand_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
         lock_clear |=> (!lock_clear || victim_o == WW'($past(victim_o) + 1)));
   end

   if (WAYS > 1 && POLICY == POL_LRR) begin : g_chk_lrr
      assert_lrr_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (fill_i && lock_clear) |=>
            (idx_i != $past(idx_i) || !lock_clear || victim_o != $past(victim_o)));
   end

   if (WAYS > 1 && POLICY == POL_LRU) begin : g_chk_lru
      assert_hit_newest_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid_i && !fill_i && int'(hit_way_i) < WAYS && lock_clear) |=>
            (idx_i != $past(idx_i) || !lock_clear || victim_o != $past(hit_way_i)));
      assert_fill_newest_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (fill_i && lock_clear) |=>
            (idx_i != $past(idx_i) || !lock_clear || victim_o != $past(victim_o)));
   end

endmodule

bind way_victim_sel wvs_check #(
   .WAYS(WAYS), .LINES(LINES), .POLICY(POLICY), .LOCK_EN(LOCK_EN)
) u_wvs_check (
   .clk          (clk),
   .rst_n        (rst_n),
   .idx_i        (idx_i),
   .acc_valid_i  (acc_valid_i),
   .hit_way_i    (hit_way_i),
   .fill_i       (fill_i),
   .lock_i       (lock_i),
   .victim_o     (victim_o),
   .all_locked_o (all_locked_o)
);

// File: tb/way_victim_sel_bench.sv
`timescale 1ns/1ps
module way_victim_sel_bench;
   import wvs_pkg::*;

   localparam int LN = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] idx = '0;
   logic       acc = 1'b0;
   logic [1:0] hit = '0;
   logic       fill = 1'b0;
   logic [3:0] lock = '0;

   logic [1:0] v4, v3, vr4, vr3;
   logic [0:0] v2, v1;
   logic       f4, f3, f2, fr4, fr3, f1;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   // reference state: last-use stamps per model, line, way
   int st [2][LN][4];
   bit last2 [LN];
   int tnow;
   int rcnt;

   always #4 clk = ~clk;   // 125 MHz

   way_victim_sel #(.WAYS(4), .LINES(LN), .POLICY(POL_LRU), .LOCK_EN(1'b1)) u_way_victim_sel (
      .clk(clk), .rst_n(rst_n), .idx_i(idx), .acc_valid_i(acc), .hit_way_i(hit),
      .fill_i(fill), .lock_i(lock), .victim_o(v4), .all_locked_o(f4));
   way_victim_sel #(.WAYS(3), .LINES(LN), .POLICY(POL_LRU), .LOCK_EN(1'b0)) u_way_victim_sel_lru3 (
      .clk(clk), .rst_n(rst_n), .idx_i(idx), .acc_valid_i(acc), .hit_way_i(hit),
      .fill_i(fill), .lock_i(lock[2:0]), .victim_o(v3), .all_locked_o(f3));
   way_victim_sel #(.WAYS(2), .LINES(LN), .POLICY(POL_LRR), .LOCK_EN(1'b1)) u_way_victim_sel_lrr2 (
      .clk(clk), .rst_n(rst_n), .idx_i(idx), .acc_valid_i(acc), .hit_way_i(hit[0:0]),
      .fill_i(fill), .lock_i(lock[1:0]), .victim_o(v2), .all_locked_o(f2));
   way_victim_sel #(.WAYS(4), .LINES(LN), .POLICY(POL_RANDOM), .LOCK_EN(1'b1)) u_way_victim_sel_rnd4 (
      .clk(clk), .rst_n(rst_n), .idx_i(idx), .acc_valid_i(acc), .hit_way_i(hit),
      .fill_i(fill), .lock_i(lock), .victim_o(vr4), .all_locked_o(fr4));
   way_victim_sel #(.WAYS(3), .LINES(LN), .POLICY(POL_RANDOM), .LOCK_EN(1'b0)) u_way_victim_sel_rnd3 (
      .clk(clk), .rst_n(rst_n), .idx_i(idx), .acc_valid_i(acc), .hit_way_i(hit),
      .fill_i(fill), .lock_i(lock[2:0]), .victim_o(vr3), .all_locked_o(fr3));
   way_victim_sel #(.WAYS(1), .LINES(LN), .POLICY(POL_LRU), .LOCK_EN(1'b1)) u_way_victim_sel_one (
      .clk(clk), .rst_n(rst_n), .idx_i(idx), .acc_valid_i(acc), .hit_way_i(hit[0:0]),
      .fill_i(fill), .lock_i(lock[0:0]), .victim_o(v1), .all_locked_o(f1));

   task automatic chk(input string req, input string scen, input string dut, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s [%s] %s: actual %0d expected %0d", req, scen, dut, act, exp);
      end
   endtask

   function automatic int lru_pick(input int m, input int n, input int l, input logic [3:0] lk);
      int best;
      int bs;
      best = n - 1;
      bs   = 32'h7fffffff;
      for (int w = 0; w < n; w++) begin
         if (!lk[w] && st[m][l][w] < bs) begin
            best = w;
            bs   = st[m][l][w];
         end
      end
      return best;
   endfunction

   function automatic int lrr_pick(input int l, input logic [1:0] lk);
      int pref;
      pref = last2[l] ? 0 : 1;
      if (!lk[pref])     return pref;
      if (!lk[1 - pref]) return 1 - pref;
      return 1;
   endfunction

   function automatic int rnd_pick(input int n, input logic [3:0] lk);
      int c;
      c = rcnt % 4;
      if (n == 3 && c == 3) c = 0;
      for (int k = 0; k < n; k++) begin
         if (!lk[(c + k) % n]) return (c + k) % n;
      end
      return n - 1;
   endfunction

   // drive one cycle, check outputs before the edge, advance the model past it
   task automatic step(input string scen, input int l, input bit a, input int h,
                       input bit f, input logic [3:0] lk);
      int e4, e3, e2, er4, er3;
      idx  = 4'(l);
      acc  = a;
      hit  = 2'(h);
      fill = f;
      lock = lk;
      #1;
      e4  = lru_pick(0, 4, l, lk);
      e3  = lru_pick(1, 3, l, 4'b0000);
      e2  = lrr_pick(l, lk[1:0]);
      er4 = rnd_pick(4, lk);
      er3 = rnd_pick(3, 4'b0000);
      chk("R5",  scen, "lru4 victim", int'(v4), e4);
      chk("R5",  scen, "lru3 victim", int'(v3), e3);
      chk("R4",  scen, "lrr2 victim", int'(v2), e2);
      chk((lk != 0) ? "R3" : "R2", scen, "rnd4 victim", int'(vr4), er4);
      chk("R2",  scen, "rnd3 victim", int'(vr3), er3);
      chk("R1",  scen, "one victim",  int'(v1), 0);
      chk("R9",  scen, "lru4 flag",   int'(f4),  int'(&lk));
      chk("R9",  scen, "lrr2 flag",   int'(f2),  int'(&lk[1:0]));
      chk("R9",  scen, "rnd4 flag",   int'(fr4), int'(&lk));
      chk("R10", scen, "lru3 flag",   int'(f3),  0);
      chk("R10", scen, "rnd3 flag",   int'(fr3), 0);
      chk("R1",  scen, "one flag",    int'(f1),  int'(lk[0]));
      if (f) begin
         st[0][l][e4] = tnow;
         st[1][l][e3] = tnow;
         last2[l]     = (e2 != 0);
      end else if (a) begin
         st[0][l][h] = tnow;
         if (h < 3) st[1][l][h] = tnow;
      end
      tnow++;
      rcnt++;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic sc_reset();
      step("R6", 0, 1'b0, 0, 1'b0, 4'b0000);
      step("R6", 9, 1'b0, 0, 1'b0, 4'b0000);
   endtask

   task automatic sc_hit_order();
      step("R5", 3, 1'b1, 0, 1'b0, 4'b0000);
      step("R5", 3, 1'b1, 1, 1'b0, 4'b0000);
      step("R5", 3, 1'b1, 3, 1'b0, 4'b0000);   // way 3 does not exist in the 3-way copy: R7
      step("R5", 3, 1'b1, 2, 1'b0, 4'b0000);
      step("R5", 3, 1'b1, 0, 1'b0, 4'b0000);
      step("R5", 3, 1'b0, 0, 1'b0, 4'b0000);
   endtask

   task automatic sc_fill_rotation();
      for (int i = 0; i < 6; i++) step("R5", 5, 1'b0, 0, 1'b1, 4'b0000);
      step("R5", 5, 1'b0, 0, 1'b0, 4'b0000);
   endtask

   task automatic sc_fill_priority();
      step("R7", 6, 1'b1, 0, 1'b0, 4'b0000);
      step("R7", 6, 1'b1, 2, 1'b1, 4'b0000);   // fill must win over the hit on way 2
      step("R7", 6, 1'b0, 0, 1'b0, 4'b0000);
   endtask

   task automatic sc_line_isolation();
      step("R8", 7, 1'b1, 0, 1'b0, 4'b0000);
      step("R8", 7, 1'b1, 1, 1'b1, 4'b0000);
      step("R11", 8, 1'b0, 0, 1'b0, 4'b0000);  // neighbour still in reset order, seen same cycle
      step("R11", 7, 1'b0, 0, 1'b0, 4'b0000);
   endtask

   task automatic sc_locks();
      step("R3", 10, 1'b0, 0, 1'b0, 4'b0001);
      step("R3", 10, 1'b0, 0, 1'b1, 4'b0011);
      step("R4", 10, 1'b0, 0, 1'b1, 4'b0101);
      step("R3", 10, 1'b0, 0, 1'b1, 4'b1110);
      step("R4", 10, 1'b0, 0, 1'b0, 4'b0010);
      step("R3", 10, 1'b0, 0, 1'b0, 4'b1011);
   endtask

   task automatic sc_all_locked();
      step("R9", 11, 1'b0, 0, 1'b0, 4'b1111);
      step("R9", 11, 1'b0, 0, 1'b1, 4'b1111);
      step("R9", 11, 1'b0, 0, 1'b0, 4'b0000);
   endtask

   task automatic sc_lock_ignored();
      step("R10", 12, 1'b0, 0, 1'b1, 4'b0111);
      step("R10", 12, 1'b1, 2, 1'b0, 4'b0111);
      step("R10", 12, 1'b0, 0, 1'b0, 4'b1111);
   endtask

   task automatic sc_random_walk();
      for (int i = 0; i < 9; i++) step("R2", i % LN, 1'b0, 0, 1'b0, 4'b0000);
   endtask

   task automatic sc_single();
      step("R1", 13, 1'b1, 0, 1'b1, 4'b0001);
      step("R1", 13, 1'b0, 0, 1'b1, 4'b0000);
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: actual still running, expected completion");
         finish_run();
      end
   end

   initial begin
      for (int m = 0; m < 2; m++)
         for (int l = 0; l < LN; l++)
            for (int w = 0; w < 4; w++) st[m][l][w] = w - 100;
      for (int l = 0; l < LN; l++) last2[l] = 1'b0;
      tnow = 0;
      rcnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      sc_reset();
      sc_hit_order();
      sc_fill_rotation();
      sc_fill_priority();
      sc_line_isolation();
      sc_locks();
      sc_all_locked();
      sc_lock_ignored();
      sc_random_walk();
      sc_single();
      done = 1'b1;
      finish_run();
   end

endmodule